// File: doc/BRIEF.md
# Deadline-Aware Operating Point Selector

This block chooses the supply-voltage and clock-frequency pair for a processor running one job with a known amount of remaining work and a hard time limit. There are three pairs. On each re-evaluate strobe the block takes the remaining cycle count and the remaining time in milliseconds, and selects the slowest pair whose clock can still finish the work in time. Finishing early at a high voltage and then idling costs more energy per operation than running slower at a lower voltage, because energy per cycle grows with the square of the supply. The block therefore never races ahead.

Between strobes, software or a progress monitor refreshes the two inputs from the work actually done. A job that is ahead of plan lands on a slower point at the next strobe. A job that is behind lands on a faster one. A progress input reports how many processor cycles ran in each clock. The block adds their energy, at the cost of the point in force, into a running estimate in nanojoules.

The feasibility test uses whole-number products: frequency in MHz times time in ms times 1000 gives the cycle capacity. No divider is needed.

Top module: `opp_selector`

## Requirements
- R1: Index 0 is 25 MHz at 2500 mV, index 1 is 40 MHz at 4000 mV, and index 2 is 50 MHz at 5000 mV. `freq_mhz` and `volt_mv` always show the values of the index on `op_idx`.
- R2: After reset, `op_idx` is 2, `energy_nj` is 0, and both `point_valid` and `deadline_miss` are 0.
- R3: On a clock edge with `reeval` high, `op_idx` takes the lowest index whose MHz × `time_left_ms` × 1000 is at least `cycles_left`.
- R4: Capacity exactly equal to `cycles_left` counts as meeting the deadline.
- R5: If no point has enough capacity, index 2 is chosen and `deadline_miss` is 1. The next strobe that finds a feasible point clears the flag.
- R6: Without `reeval`, changes on `cycles_left` and `time_left_ms` leave `op_idx` and `deadline_miss` unchanged.
- R7: `point_valid` is high for exactly the one cycle after each edge where `reeval` was high.
- R8: On each edge, `energy_nj` grows by `exec_cycles` times the per-cycle cost of the current point: 10, 25 or 40 nJ for index 0, 1 or 2.
- R9: When `exec_cycles` and a strobe fall on the same edge, those cycles are charged at the point that was in force before that edge.
- R10: Lowering `cycles_left` relative to `time_left_ms` (ahead of plan) moves the selection to a slower point. Raising it (behind plan) moves the selection to a faster point.
- R11: Each of these work plans reaches the stated total: 10^9 cycles at index 2 gives 40×10^9 nJ; 750×10^6 cycles at index 2 followed by 250×10^6 cycles at index 0 gives 32.5×10^9 nJ; 10^9 cycles at index 1 gives 25×10^9 nJ.
- R12: A strobe with `cycles_left` equal to 0 selects index 0, even when `time_left_ms` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reeval | input | 1 | Strobe: recompute the operating point on this edge |
| cycles_left | input | 32 | Processor cycles still needed by the job |
| time_left_ms | input | 32 | Milliseconds left before the deadline |
| exec_cycles | input | 32 | Processor cycles executed during this clock |
| op_idx | output | 2 | Selected operating point index |
| freq_mhz | output | 8 | Clock frequency of the selected point, in MHz |
| volt_mv | output | 13 | Supply voltage of the selected point, in mV |
| energy_nj | output | 64 | Accumulated energy estimate, in nJ |
| point_valid | output | 1 | One-cycle pulse after each re-evaluation |
| deadline_miss | output | 1 | No point could meet the deadline at the last re-evaluation |

## Verification
Selection is driven from a table of work/time pairs placed around each capacity threshold:
- Pairs exactly at a threshold separate an inclusive comparison from a strict one.
- Pairs one cycle over a threshold expose an off-by-one in the capacity product.
- The zero-work and zero-time pairs tell a correct fallback apart from a misordered priority scan.

Directed sequences then cover the remaining behaviour:
- Ahead-of-plan and behind-of-plan updates show that the speed moves both down and up.
- A same-edge charge-and-switch step shows which point's cost applies to those cycles.
- Three reference work plans check that the energy costs are not swapped between points.

// File: rtl/opp_pkg.sv
package opp_pkg;
    localparam int unsigned NUM_PTS        = 3;
    localparam int unsigned IDX_W          = $clog2(NUM_PTS);
    localparam int unsigned CYC_PER_MHZ_MS = 1000;

    // ordered slowest to fastest; the selection scan depends on this order
    localparam int unsigned PT_MHZ [NUM_PTS] = '{25, 40, 50};
    localparam int unsigned PT_MV  [NUM_PTS] = '{2500, 4000, 5000};
    localparam int unsigned PT_NJ  [NUM_PTS] = '{10, 25, 40};

    typedef logic [IDX_W-1:0] pt_idx_t;
    localparam pt_idx_t TOP_PT = pt_idx_t'(NUM_PTS - 1);

    typedef struct packed {
        pt_idx_t idx;
        logic    miss;
        logic    valid;
    } sel_state_t;
endpackage

// File: rtl/opp_fit_check.sv
module opp_fit_check
    import opp_pkg::*;
#(
    parameter int unsigned CYC_W  = 32,
    parameter int unsigned TIME_W = 32
) (
    input  logic [CYC_W-1:0]   cycles_left,
    input  logic [TIME_W-1:0]  time_left_ms,
    output logic [NUM_PTS-1:0] fits
);
    localparam int unsigned PW = 64;

    for (genvar g = 0; g < NUM_PTS; g++) begin : g_pt
        logic [PW-1:0] cap;
        assign cap     = PW'(time_left_ms) * PW'(PT_MHZ[g] * CYC_PER_MHZ_MS);
        assign fits[g] = (cap >= PW'(cycles_left));
    end

    // a faster point never has less capacity than a slower one
    always_comb begin
        if (!$isunknown({cycles_left, time_left_ms})) begin
            for (int i = 0; i < NUM_PTS - 1; i++) begin
                assert_fit_monotone_R3: assert (!fits[i] || fits[i+1]);
            end
        end
    end
endmodule

// File: rtl/opp_energy_acc.sv
module opp_energy_acc
    import opp_pkg::*;
#(
    parameter int unsigned EXEC_W   = 32,
    parameter int unsigned ENERGY_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [EXEC_W-1:0]   exec_cycles,
    input  pt_idx_t             cur_idx,
    output logic [ENERGY_W-1:0] energy
);
    logic [ENERGY_W-1:0] energy_d, energy_q;
    logic [ENERGY_W-1:0] step_cost;

    always_comb begin
        step_cost = ENERGY_W'(PT_NJ[cur_idx]);
        energy_d  = energy_q + ENERGY_W'(exec_cycles) * step_cost;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) energy_q <= '0;
        else        energy_q <= energy_d;
    end

    assign energy = energy_q;

    assert_energy_grows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> energy >= $past(energy));
    assert_energy_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_cycles == '0) |=> $stable(energy));
endmodule

// File: rtl/opp_selector.sv
module opp_selector
    import opp_pkg::*;
#(
    parameter int unsigned CYC_W    = 32,
    parameter int unsigned TIME_W   = 32,
    parameter int unsigned EXEC_W   = 32,
    parameter int unsigned ENERGY_W = 64,
    parameter int unsigned FREQ_W   = 8,
    parameter int unsigned VOLT_W   = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reeval,
    input  logic [CYC_W-1:0]    cycles_left,
    input  logic [TIME_W-1:0]   time_left_ms,
    input  logic [EXEC_W-1:0]   exec_cycles,
    output logic [IDX_W-1:0]    op_idx,
    output logic [FREQ_W-1:0]   freq_mhz,
    output logic [VOLT_W-1:0]   volt_mv,
    output logic [ENERGY_W-1:0] energy_nj,
    output logic                point_valid,
    output logic                deadline_miss
);
    logic [NUM_PTS-1:0] fits;
    pt_idx_t            pick_idx;
    logic               none_fit;
    sel_state_t         st_d, st_q;

    opp_fit_check #(.CYC_W(CYC_W), .TIME_W(TIME_W)) u_fit (
        .cycles_left (cycles_left),
        .time_left_ms(time_left_ms),
        .fits        (fits)
    );

    // scan fastest to slowest so that the slowest fitting point wins
    always_comb begin
        pick_idx = TOP_PT;
        none_fit = 1'b1;
        for (int i = NUM_PTS - 1; i >= 0; i--) begin
            if (fits[i]) begin
                pick_idx = pt_idx_t'(i);
                none_fit = 1'b0;
            end
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (reeval) begin
            st_d.idx   = pick_idx;
            st_d.miss  = none_fit;
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{idx: TOP_PT, miss: 1'b0, valid: 1'b0};
        else        st_q <= st_d;
    end

    opp_energy_acc #(.EXEC_W(EXEC_W), .ENERGY_W(ENERGY_W)) u_energy (
        .clk        (clk),
        .rst_n      (rst_n),
        .exec_cycles(exec_cycles),
        .cur_idx    (st_q.idx),
        .energy     (energy_nj)
    );

    assign op_idx        = st_q.idx;
    assign freq_mhz      = FREQ_W'(PT_MHZ[st_q.idx]);
    assign volt_mv       = VOLT_W'(PT_MV[st_q.idx]);
    assign point_valid   = st_q.valid;
    assign deadline_miss = st_q.miss;

    assert_idx_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        op_idx < IDX_W'(NUM_PTS));
    assert_miss_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        deadline_miss |-> (op_idx == TOP_PT));
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !reeval |=> ($stable(op_idx) && $stable(deadline_miss)));
    assert_pulse_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reeval |=> point_valid);
    assert_pulse_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !reeval |=> !point_valid);
endmodule

// File: tb/opp_selector_bench.sv
`timescale 1ns/1ps
module opp_selector_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reeval = 1'b0;
    logic [31:0] cycles_left = '0;
    logic [31:0] time_left_ms = '0;
    logic [31:0] exec_cycles = '0;
    logic [1:0]  op_idx;
    logic [7:0]  freq_mhz;
    logic [12:0] volt_mv;
    logic [63:0] energy_nj;
    logic        point_valid;
    logic        deadline_miss;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    opp_selector u_opp_selector (
        .clk(clk), .rst_n(rst_n), .reeval(reeval),
        .cycles_left(cycles_left), .time_left_ms(time_left_ms),
        .exec_cycles(exec_cycles), .op_idx(op_idx), .freq_mhz(freq_mhz),
        .volt_mv(volt_mv), .energy_nj(energy_nj),
        .point_valid(point_valid), .deadline_miss(deadline_miss)
    );

    // {cycles, time_ms, expected index, expected miss}
    localparam int NV = 9;
    localparam logic [66:0] VEC [NV] = '{
        {32'd1000000000, 32'd25000,  2'd1, 1'b0},  // R3 reference job
        {32'd625000000,  32'd25000,  2'd0, 1'b0},  // R4 equal at slowest
        {32'd625000001,  32'd25000,  2'd1, 1'b0},  // R3 one over
        {32'd1250000000, 32'd25000,  2'd2, 1'b0},  // R4 equal at fastest
        {32'd1250000001, 32'd25000,  2'd2, 1'b1},  // R5 infeasible
        {32'd0,          32'd0,      2'd0, 1'b0},  // R12 no work
        {32'd1,          32'd0,      2'd2, 1'b1},  // R5 no time
        {32'd100000,     32'd4,      2'd0, 1'b0},  // R4 small equal
        {32'd4000000000, 32'd100000, 2'd1, 1'b0}   // R3 large widths
    };

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_mhz(logic [1:0] i);
        return (i == 2'd0) ? 8'd25 : (i == 2'd1) ? 8'd40 : 8'd50;
    endfunction

    function automatic logic [12:0] exp_mv(logic [1:0] i);
        return (i == 2'd0) ? 13'd2500 : (i == 2'd1) ? 13'd4000 : 13'd5000;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; reeval = 1'b0; exec_cycles = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // raise the strobe for one edge; returns at the negedge after it
    task automatic strobe(logic [31:0] c, logic [31:0] t);
        @(negedge clk);
        cycles_left = c; time_left_ms = t; reeval = 1'b1;
        @(negedge clk);
        reeval = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R2 reset state
        check("R2 idx", 64'(op_idx), 64'd2);
        check("R2 energy", energy_nj, 64'd0);
        check("R2 valid", 64'(point_valid), 64'd0);
        check("R2 miss", 64'(deadline_miss), 64'd0);
        check("R1 reset freq", 64'(freq_mhz), 64'd50);

        for (int k = 0; k < NV; k++) begin
            strobe(VEC[k][66:35], VEC[k][34:3]);
            check($sformatf("R3 vec%0d idx", k), 64'(op_idx), 64'(VEC[k][2:1]));
            check($sformatf("R5 vec%0d miss", k), 64'(deadline_miss), 64'(VEC[k][0]));
            check($sformatf("R1 vec%0d freq", k), 64'(freq_mhz), 64'(exp_mhz(VEC[k][2:1])));
            check($sformatf("R1 vec%0d volt", k), 64'(volt_mv), 64'(exp_mv(VEC[k][2:1])));
            check($sformatf("R7 vec%0d pulse", k), 64'(point_valid), 64'd1);
            @(negedge clk);
            check($sformatf("R7 vec%0d drop", k), 64'(point_valid), 64'd0);
        end

        // R5 flag clears once feasible again
        strobe(32'd1, 32'd0);
        check("R5 miss set", 64'(deadline_miss), 64'd1);
        strobe(32'd1, 32'd1);
        check("R5 miss cleared", 64'(deadline_miss), 64'd0);
        check("R5 idx after clear", 64'(op_idx), 64'd0);

        // R6 inputs without strobe are ignored
        strobe(32'd1250000001, 32'd25000);
        @(negedge clk);
        cycles_left = 32'd0; time_left_ms = 32'd1000;
        repeat (3) @(negedge clk);
        check("R6 idx held", 64'(op_idx), 64'd2);
        check("R6 miss held", 64'(deadline_miss), 64'd1);
        check("R6 no pulse", 64'(point_valid), 64'd0);

        // R10 ahead lowers, behind raises
        strobe(32'd1000000000, 32'd25000);
        check("R10 start", 64'(op_idx), 64'd1);
        strobe(32'd500000000, 32'd20000);
        check("R10 ahead lowered", 64'(op_idx), 64'd0);
        strobe(32'd900000000, 32'd20000);
        check("R10 behind raised", 64'(op_idx), 64'd2);

        // R11 plan A: all at fastest point
        do_reset();
        strobe(32'd1250000000, 32'd25000);
        exec_cycles = 32'd1000000000;
        @(negedge clk);
        exec_cycles = '0;
        check("R8 R11 plan A", energy_nj, 64'd40000000000);
        @(negedge clk);
        check("R8 idle hold", energy_nj, 64'd40000000000);

        // R11 plan B with R9 same-edge switch
        do_reset();
        strobe(32'd1250000000, 32'd25000);
        exec_cycles = 32'd750000000;
        cycles_left = 32'd250000000; time_left_ms = 32'd10000; reeval = 1'b1;
        @(negedge clk);
        reeval = 1'b0;
        exec_cycles = 32'd250000000;
        check("R9 old point charged", energy_nj, 64'd30000000000);
        check("R9 switched", 64'(op_idx), 64'd0);
        @(negedge clk);
        exec_cycles = '0;
        check("R11 plan B", energy_nj, 64'd32500000000);

        // R11 plan C: all at middle point
        do_reset();
        strobe(32'd1000000000, 32'd25000);
        check("R11 plan C idx", 64'(op_idx), 64'd1);
        exec_cycles = 32'd1000000000;
        @(negedge clk);
        exec_cycles = '0;
        check("R11 plan C", energy_nj, 64'd25000000000);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule